// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is one transmit DMA channel. It follows a chain of descriptors held in a 32-bit word memory and sends each referenced buffer out as a byte stream with a valid/ready handshake. Every descriptor is four words long. Software writes the address of the first descriptor into the head pointer, which starts the channel. The engine then fetches each descriptor and confirms that it owns it. It streams the buffer, then hands the descriptor back with a single write of its mode word. That write clears the owner flag and marks either end-of-queue or teardown-complete.

The engine reports each finished descriptor in two ways: it loads the descriptor's address into the completion pointer and raises a one-cycle done pulse. Software acknowledges a descriptor by writing its address back to the completion pointer. A teardown command lets the descriptor in flight finish and then stops the channel. The stop is reported by the sentinel value 0xFFFFFFFC in the completion pointer. Software acknowledges it by writing the same sentinel back.

Top module: `txq_desc_engine`

## Requirements
- R1: A descriptor at byte address A is fetched as four word reads: A holds the next pointer, A+4 the buffer address, A+8 the byte count (low 11 bits used), and A+12 the mode word.
- R2: The buffer is sent least-significant byte of each word first, exactly byte-count bytes. tx_last is high on the final byte. tx_valid and tx_data hold steady while tx_ready is low. A byte count of zero sends nothing.
- R3: After the final byte, the engine makes exactly one memory write, to A+12. The written word is the fetched mode word with the owner bit (bit 29) cleared and every other bit unchanged, except bit 28 and bit 27 as set by R5 and R10. This preserves the directed-port bits 20 and 18:16 and the length field 10:0.
- R4: When the next pointer is nonzero, the engine goes on to that descriptor, and head_ptr shows the descriptor being processed.
- R5: When the next pointer is zero, the write-back also sets end-of-queue (bit 28). The channel then goes idle with head_ptr equal to 0.
- R6: While the channel is idle, a head write (reg_sel=0) with a nonzero value restarts it at that address.
- R7: A head write while busy is ignored. head_ptr keeps its value and the written chain is not touched.
- R8: A descriptor whose owner bit is 0 at fetch stops the channel. The engine makes no memory write, raises err for one cycle and sends no bytes.
- R9: Each finished descriptor raises done for exactly one cycle. Unless a teardown is pending, it also loads the descriptor's address into cpl_ptr.
- R10: A teardown while busy lets the current descriptor finish, sets teardown-complete (bit 27) instead of end-of-queue in its write-back, loads cpl_ptr with 0xFFFFFFFC and goes idle. A teardown while idle loads the sentinel at once.
- R11: A software write with reg_sel=1 stores reg_wdata in cpl_ptr. This is how completions and the teardown sentinel are acknowledged.
- R12: After reset the channel is idle, both pointers are zero, and tx_valid, done, err and the memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the head pointer, 1 selects the completion pointer |
| reg_wdata | input | 32 | Register write data |
| head_ptr | output | 32 | Head pointer (current descriptor) |
| cpl_ptr | output | 32 | Completion pointer |
| teardown_req | input | 1 | One-cycle teardown command |
| mem_rd | output | 1 | Memory read strobe; data is returned one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Byte address of the memory access |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the cycle after mem_rd |
| tx_valid | output | 1 | Byte valid |
| tx_data | output | 8 | Byte data |
| tx_last | output | 1 | Final byte of a buffer |
| tx_ready | input | 1 | Byte sink ready |
| busy | output | 1 | Channel is processing a chain |
| done | output | 1 | One-cycle pulse per finished descriptor |
| err | output | 1 | One-cycle pulse when an unowned descriptor is found |

## Verification
The hardest states to reach are those where a command arrives in the middle of a buffer. These are a teardown request, or a head write that must be ignored, arriving while a descriptor is still streaming. The bench reaches them by giving that descriptor a long buffer and holding tx_ready low most of the time. It then issues the command a fixed number of cycles after the start, which is well inside the streaming window. Random chains with random lengths (zero and one included), random directed-port bits and random sink stalls cover the chaining, word-boundary and back-pressure cases.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int OWN_B = 29;
  localparam int EOQ_B = 28;
  localparam int TDC_B = 27;
  localparam logic [31:0] TD_SENTINEL = 32'hFFFF_FFFC;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_CHECK, S_BREAD, S_BWAIT, S_STREAM, S_WBACK
  } txq_state_t;
endpackage

// File: rtl/txq_ptr_regs.sv
module txq_ptr_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          busy,
  input  logic          hw_head_we,
  input  logic [DW-1:0] hw_head_val,
  input  logic          hw_cpl_we,
  input  logic [DW-1:0] hw_cpl_val,
  output logic [DW-1:0] head_ptr,
  output logic [DW-1:0] cpl_ptr,
  output logic          start,
  output logic [DW-1:0] start_addr
);
  logic sw_head;

  assign sw_head    = reg_wr && !reg_sel && !busy;
  assign start      = sw_head && (reg_wdata != '0);
  assign start_addr = reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_ptr <= '0;
      cpl_ptr  <= '0;
    end else begin
      if (hw_head_we)   head_ptr <= hw_head_val;
      else if (sw_head) head_ptr <= reg_wdata;
      if (hw_cpl_we)               cpl_ptr <= hw_cpl_val;
      else if (reg_wr && reg_sel)  cpl_ptr <= reg_wdata;
    end
  end

  // R7: a head write while busy must leave the pointer alone
  a_r7_head_ignored_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && !reg_sel && !hw_head_we) |=> $stable(head_ptr));
endmodule

// File: rtl/txq_chan_ctrl.sv
module txq_chan_ctrl
  import txq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] start_addr,
  input  logic          teardown_req,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          hw_head_we,
  output logic [DW-1:0] hw_head_val,
  output logic          hw_cpl_we,
  output logic [DW-1:0] hw_cpl_val
);
  localparam int LANES  = DW / 8;
  localparam int LANE_W = $clog2(LANES) + 1;
  localparam logic [LEN_W-1:0]  LEN_ONE  = 1;
  localparam logic [LANE_W-1:0] LANE_ONE = 1;
  localparam logic [LANE_W-1:0] LANE_ALL = LANE_W'(LANES);
  localparam logic [DW-1:0]     WSTEP    = DW'(LANES);
  localparam logic [DW-1:0]     MODE_OFS = DW'(3 * LANES);

  txq_state_t          state;
  logic [DW-1:0]       cur, d_next, d_buf, d_mode, bptr, word;
  logic [LEN_W-1:0]    d_len, remain;
  logic [1:0]          widx;
  logic [LANE_W-1:0]   lane_cnt;
  logic                td_pend, done_q, err_q;
  logic                own, td_now, chain_on, bad_own;
  logic [DW-1:0]       wb_mode;

  assign own      = d_mode[OWN_B];
  assign td_now   = td_pend || teardown_req;
  assign chain_on = !td_now && (d_next != '0);
  assign bad_own  = (state == S_CHECK) && !own;

  always_comb begin
    wb_mode        = d_mode;
    wb_mode[OWN_B] = 1'b0;
    if (td_now)              wb_mode[TDC_B] = 1'b1;
    else if (d_next == '0)   wb_mode[EOQ_B] = 1'b1;
  end

  always_comb begin
    mem_rd    = (state == S_FETCH) || (state == S_BREAD);
    mem_wr    = (state == S_WBACK);
    mem_wdata = wb_mode;
    case (state)
      S_FETCH: mem_addr = cur + {{(DW-4){1'b0}}, widx, 2'b00};
      S_BREAD: mem_addr = bptr;
      S_WBACK: mem_addr = cur + MODE_OFS;
      default: mem_addr = '0;
    endcase
  end

  assign tx_valid    = (state == S_STREAM);
  assign tx_data     = word[7:0];
  assign tx_last     = (state == S_STREAM) && (remain == LEN_ONE);
  assign busy        = (state != S_IDLE);
  assign done        = done_q;
  assign err         = err_q;
  assign hw_head_we  = (state == S_WBACK) || bad_own;
  assign hw_head_val = ((state == S_WBACK) && chain_on) ? d_next : '0;
  assign hw_cpl_we   = (state == S_WBACK) || (bad_own && td_pend) ||
                       ((state == S_IDLE) && teardown_req);
  assign hw_cpl_val  = ((state == S_WBACK) && !td_now) ? cur : TD_SENTINEL;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cur      <= '0;
      d_next   <= '0;
      d_buf    <= '0;
      d_len    <= '0;
      d_mode   <= '0;
      bptr     <= '0;
      word     <= '0;
      remain   <= '0;
      widx     <= '0;
      lane_cnt <= '0;
      td_pend  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (teardown_req) td_pend <= 1'b1;
      case (state)
        S_IDLE: begin
          td_pend <= 1'b0;
          if (start) begin
            cur   <= start_addr;
            widx  <= '0;
            state <= S_FETCH;
          end
        end
        S_FETCH: state <= S_FWAIT;
        S_FWAIT: begin
          case (widx)
            2'd0:    d_next <= mem_rdata;
            2'd1:    d_buf  <= mem_rdata;
            2'd2:    d_len  <= mem_rdata[LEN_W-1:0];
            default: d_mode <= mem_rdata;
          endcase
          if (widx == 2'd3) state <= S_CHECK;
          else begin
            widx  <= widx + 2'd1;
            state <= S_FETCH;
          end
        end
        S_CHECK: begin
          if (!own) begin
            err_q   <= 1'b1;
            td_pend <= 1'b0;
            state   <= S_IDLE;
          end else begin
            bptr   <= d_buf;
            remain <= d_len;
            state  <= (d_len == '0) ? S_WBACK : S_BREAD;
          end
        end
        S_BREAD: state <= S_BWAIT;
        S_BWAIT: begin
          word     <= mem_rdata;
          lane_cnt <= LANE_ALL;
          state    <= S_STREAM;
        end
        S_STREAM: begin
          if (tx_ready) begin
            word     <= word >> 8;
            remain   <= remain - LEN_ONE;
            lane_cnt <= lane_cnt - LANE_ONE;
            if (remain == LEN_ONE) state <= S_WBACK;
            else if (lane_cnt == LANE_ONE) begin
              bptr  <= bptr + WSTEP;
              state <= S_BREAD;
            end
          end
        end
        S_WBACK: begin
          done_q  <= 1'b1;
          td_pend <= 1'b0;
          if (chain_on) begin
            cur   <= d_next;
            widx  <= '0;
            state <= S_FETCH;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: the hand-back write returns ownership
  a_r3_owner_cleared: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !mem_wdata[OWN_B]);
  // R3: one write per descriptor
  a_r3_single_write: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);
  // R5/R10: end-of-queue and teardown-complete never together
  a_r10_eoq_tdc_exclusive: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !(mem_wdata[EOQ_B] && mem_wdata[TDC_B]));
  // R2: byte held while the sink stalls
  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R8: error is a single-cycle pulse and no write follows it
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  a_r8_err_no_write: assert property (@(posedge clk) disable iff (rst)
    err |-> (!mem_wr && !busy));
  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1: reads and writes never collide
  a_r1_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

// File: rtl/txq_desc_engine.sv
module txq_desc_engine #(
  parameter int DW    = 32,
  parameter int LEN_W = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] head_ptr,
  output logic [DW-1:0] cpl_ptr,
  input  logic          teardown_req,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          busy,
  output logic          done,
  output logic          err
);
  logic          start, hw_head_we, hw_cpl_we;
  logic [DW-1:0] start_addr, hw_head_val, hw_cpl_val;

  txq_ptr_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy(busy),
    .hw_head_we(hw_head_we), .hw_head_val(hw_head_val),
    .hw_cpl_we(hw_cpl_we), .hw_cpl_val(hw_cpl_val),
    .head_ptr(head_ptr), .cpl_ptr(cpl_ptr),
    .start(start), .start_addr(start_addr)
  );

  txq_chan_ctrl #(.DW(DW), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .teardown_req(teardown_req),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .busy(busy), .done(done), .err(err),
    .hw_head_we(hw_head_we), .hw_head_val(hw_head_val),
    .hw_cpl_we(hw_cpl_we), .hw_cpl_val(hw_cpl_val)
  );
endmodule

// File: tb/test_txq_desc_engine.sv
module test_txq_desc_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] OWN = 32'h2000_0000;
  localparam logic [31:0] EOQ = 32'h1000_0000;
  localparam logic [31:0] TDC = 32'h0800_0000;
  localparam logic [31:0] SOPEOP = 32'hC000_0000;
  localparam logic [31:0] SENT = 32'hFFFF_FFFC;

  logic        clk = 0, rst = 1;
  logic        reg_wr = 0, reg_sel = 0, teardown_req = 0, tx_ready = 0;
  logic [31:0] reg_wdata = 0, mem_rdata = 0;
  logic [31:0] head_ptr, cpl_ptr, mem_addr, mem_wdata;
  logic        mem_rd, mem_wr, tx_valid, tx_last, busy, done, err;
  logic [7:0]  tx_data;

  logic [31:0] mem [0:1023];
  logic [7:0]  rx_q[$];
  logic [7:0]  exp_q[$];
  int n_checks = 0, n_err = 0, cyc = 0;
  int done_cnt = 0, err_cnt = 0, wr_cnt = 0, last_cnt = 0, rdy_pct = 100;

  txq_desc_engine i_txq_desc_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .head_ptr(head_ptr), .cpl_ptr(cpl_ptr),
    .teardown_req(teardown_req), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .busy(busy), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_wr) begin
      mem[mem_addr[11:2]] <= mem_wdata;
      wr_cnt++;
    end
    if (done) done_cnt++;
    if (err) err_cnt++;
    cyc++;
    if (cyc == 150000) begin
      n_err++;
      $display("FAIL watchdog expired (R12 run), actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  always @(negedge clk) begin
    tx_ready = ($urandom % 100) < rdy_pct;
    if (tx_valid && tx_ready) begin
      rx_q.push_back(tx_data);
      if (tx_last) last_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] val);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 0;
  endtask

  function automatic logic [31:0] daddr(input int k);
    return 32'h100 + 32'(k * 16);
  endfunction

  function automatic logic [31:0] baddr(input int k);
    return 32'h800 + 32'(k * 64);
  endfunction

  // bench-side expected mode word for the hand-back
  function automatic logic [31:0] exp_mode(input logic [31:0] m, input bit last, input bit td);
    logic [31:0] r;
    r = m & ~OWN;
    if (td) r = r | TDC;
    else if (last) r = r | EOQ;
    return r;
  endfunction

  task automatic build(input int k, input logic [31:0] nxt, input int len, input bit own);
    logic [31:0] m;
    m = SOPEOP | 32'(len);
    if (own) m = m | OWN;
    if ($urandom % 2) m = m | 32'h0010_0000 | ({29'd0, 3'($urandom)} << 16);
    mem[daddr(k) >> 2]       = nxt;
    mem[(daddr(k) >> 2) + 1] = baddr(k);
    mem[(daddr(k) >> 2) + 2] = 32'(len);
    mem[(daddr(k) >> 2) + 3] = m;
    for (int w = 0; w < 16; w++) mem[(baddr(k) >> 2) + w] = $urandom;
  endtask

  task automatic push_exp(input int k, input int len);
    for (int b = 0; b < len; b++)
      exp_q.push_back(8'(mem[(baddr(k) >> 2) + b/4] >> (8*(b%4))));
  endtask

  task automatic clear_counts();
    @(negedge clk);
    done_cnt = 0; err_cnt = 0; wr_cnt = 0; last_cnt = 0;
    rx_q.delete(); exp_q.delete();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_bytes(input string req);
    int bad;
    bad = 0;
    if (rx_q.size() != exp_q.size()) bad = 1;
    else for (int i = 0; i < rx_q.size(); i++) if (rx_q[i] !== exp_q[i]) bad = 1;
    chk(req, 32'(rx_q.size()) | (bad ? 32'h8000_0000 : 0), 32'(exp_q.size()));
  endtask

  initial begin
    int unsigned s;
    logic [31:0] modes [0:7];
    s = $urandom(32'd2024);
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 busy", {31'd0, busy}, 0);
    chk("R12 head_ptr", head_ptr, 0);
    chk("R12 cpl_ptr", cpl_ptr, 0);
    chk("R12 outputs", {28'd0, tx_valid, done, err, mem_rd | mem_wr}, 0);

    // R1 R2 R3 R4 R5 R6 R9: random chains, each started from idle
    for (int t = 0; t < 8; t++) begin
      int n;
      int lens [0:3];
      clear_counts();
      n = 1 + int'($urandom % 4);
      rdy_pct = 40 + int'($urandom % 61);
      for (int k = 0; k < n; k++) begin
        lens[k] = int'($urandom % 21);
        if (t == 0 && k == 0) lens[k] = 0;
        if (t == 1 && k == 0) lens[k] = 1;
        build(k, (k == n-1) ? 32'd0 : daddr(k+1), lens[k], 1);
        modes[k] = mem[(daddr(k) >> 2) + 3];
        push_exp(k, lens[k]);
      end
      reg_write(0, daddr(0));
      chk("R4 head shows first descriptor", head_ptr, daddr(0));
      wait_idle();
      cmp_bytes("R2 byte stream (R1 fetch order)");
      begin
        int nz;
        nz = 0;
        for (int k = 0; k < n; k++) if (lens[k] != 0) nz++;
        chk("R2 tx_last count", 32'(last_cnt), 32'(nz));
      end
      for (int k = 0; k < n; k++)
        chk("R3 R5 mode write-back", mem[(daddr(k) >> 2) + 3], exp_mode(modes[k], k == n-1, 0));
      chk("R3 one write per descriptor", 32'(wr_cnt), 32'(n));
      chk("R9 done pulses", 32'(done_cnt), 32'(n));
      chk("R9 completion pointer", cpl_ptr, daddr(n-1));
      chk("R5 head zero at end", head_ptr, 0);
      chk("R6 idle after chain", {31'd0, busy}, 0);
    end

    // R7: head write while busy is ignored
    clear_counts();
    rdy_pct = 25;
    build(0, 0, 40, 1);
    modes[0] = mem[(daddr(0) >> 2) + 3];
    push_exp(0, 40);
    build(6, 0, 8, 1);
    modes[6] = mem[(daddr(6) >> 2) + 3];
    reg_write(0, daddr(0));
    repeat (15) @(negedge clk);
    reg_write(0, daddr(6));
    chk("R7 head kept while busy", head_ptr, daddr(0));
    wait_idle();
    chk("R7 second chain untouched", mem[(daddr(6) >> 2) + 3], modes[6]);
    chk("R7 single done", 32'(done_cnt), 1);
    cmp_bytes("R7 only first buffer sent");

    // R8: unowned descriptor
    clear_counts();
    rdy_pct = 100;
    build(2, daddr(3), 12, 0);
    modes[2] = mem[(daddr(2) >> 2) + 3];
    reg_write(0, daddr(2));
    wait_idle();
    chk("R8 err pulse count", 32'(err_cnt), 1);
    chk("R8 no memory write", 32'(wr_cnt), 0);
    chk("R8 mode unchanged (no EOQ)", mem[(daddr(2) >> 2) + 3], modes[2]);
    chk("R8 no bytes", 32'(rx_q.size()), 0);
    chk("R8 no done", 32'(done_cnt), 0);

    // R10: teardown in the middle of a buffer
    clear_counts();
    rdy_pct = 50;
    build(0, daddr(1), 30, 1);
    build(1, daddr(2), 30, 1);
    build(2, 0, 30, 1);
    modes[0] = mem[(daddr(0) >> 2) + 3];
    modes[1] = mem[(daddr(1) >> 2) + 3];
    push_exp(0, 30);
    reg_write(0, daddr(0));
    repeat (20) @(negedge clk);
    teardown_req = 1;
    @(negedge clk);
    teardown_req = 0;
    wait_idle();
    chk("R10 teardown-complete on returned descriptor", mem[(daddr(0) >> 2) + 3], exp_mode(modes[0], 0, 1));
    chk("R10 next descriptor untouched", mem[(daddr(1) >> 2) + 3], modes[1]);
    chk("R10 sentinel in completion pointer", cpl_ptr, SENT);
    chk("R10 one done", 32'(done_cnt), 1);
    chk("R10 head cleared", head_ptr, 0);
    cmp_bytes("R10 current buffer completed");

    // R11: acknowledge writes
    reg_write(1, SENT);
    chk("R11 sentinel ack stored", cpl_ptr, SENT);
    reg_write(1, 32'h0000_0140);
    chk("R11 completion ack stored", cpl_ptr, 32'h0000_0140);

    // R10: teardown while idle
    reg_write(1, 0);
    @(negedge clk);
    teardown_req = 1;
    @(negedge clk);
    teardown_req = 0;
    chk("R10 idle teardown sentinel", cpl_ptr, SENT);
    chk("R10 idle stays idle", {31'd0, busy}, 0);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule